// File: doc/BRIEF.md
# Configuration Request Issuer

This block lets software on a root port send one-dword configuration read and write requests without building packets itself. Software fills in three header registers, and a write-data register when the request carries data. It then writes 1 to the trigger bit of the request register. The engine copies the header words at that moment. It presents them one by one on a valid/ready output stream, with the data word as a fourth beat when the header's format says the request carries data.

After the last beat the engine waits for a completion. A completion brings a 3-bit status and, for reads, a 32-bit payload. The request register reports both the busy bit and the completion status, so software launches a request and polls for its result in the same place. A programmable cycle limit ends the wait if no completion arrives. The engine then reports the all-ones failure status, so the busy bit always clears.

Top module: `cfgreq_issuer`

## Requirements
- R1: After reset the request register (0x488) reads 0, the read-data register (0x48C) reads 0, the timeout-limit register (0x490) reads the parameter `TMO_DEF`, and `tx_valid` is low.
- R2: The registers sit at the following byte offsets:
  - header words 0, 1 and 2 at 0x460, 0x464 and 0x468;
  - write data at 0x470;
  - the timeout limit at 0x490, in its low `TW` bits.

  The header, write-data and timeout registers read back the last value written. A read presents its value on `reg_rdata` one cycle after `reg_re`.
- R3: Writing a word with bit 0 set to the request register while idle starts a request. Bit 0 (busy) then reads 1 and bits 7:5 (status) read 0 until the request ends.
- R4: The output stream works as follows:
  - A request whose header word 0 has bit 30 clear sends exactly three beats: header 0, then 1, then 2.
  - When bit 30 is set (write format 2 in bits 31:29), a fourth beat carries the write-data word.
  - `tx_last` marks the final beat.
  - A beat is held unchanged while `tx_ready` is low.
- R5: The beats sent are the register values at the moment of the trigger. Writes to the header or write-data registers during a request do not change them.
- R6: A completion (`cpl_valid`) taken after the last beat ends the request. Busy reads 0 and bits 7:5 hold `cpl_status`. For a request without data, the read-data register takes `cpl_data`. For a request with data, the read-data register keeps its value.
- R7: A trigger written while a request is outstanding is ignored. No extra beats are sent and the request still ends as for a single trigger.
- R8: A completion that arrives while idle, or while beats are still being sent, is ignored. Status, read data and busy are unchanged.
- R9: Let L be the timeout limit. The wait starts on the first cycle after the last beat. A completion in wait cycle k is accepted for k = 0 to L. If no completion arrives by wait cycle L, the request ends with status 3'b111 and read data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, valid one cycle after `reg_re` |
| tx_valid | output | 1 | Request beat valid |
| tx_ready | input | 1 | Request beat accepted |
| tx_data | output | DW | Request beat (header word or write data) |
| tx_last | output | 1 | Final beat of the request |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status, nonzero means failure |
| cpl_data | input | DW | Completion payload for reads |

## Verification
The assertions take three things for granted about the inputs:
- The timeout limit is rewritten only while the engine is idle, because the wait-window check compares its own counter with the live limit.
- `tx_ready` may toggle freely.
- `cpl_valid` may be a single-cycle pulse at any time, including while idle or while beats are still going out.

The stimulus keeps to these. It programs the limit only between requests, and it drives completions in every phase. Among them is the exact cycle where the wait counter equals the limit, and the cycle one later.

// File: rtl/cfgreq_pkg.sv
package cfgreq_pkg;
  localparam logic [11:0] OFF_HDR0  = 12'h460;
  localparam logic [11:0] OFF_WDATA = 12'h470;
  localparam logic [11:0] OFF_REQ   = 12'h488;
  localparam logic [11:0] OFF_RDATA = 12'h48C;
  localparam logic [11:0] OFF_TMO   = 12'h490;
  localparam int NUM_HDR      = 3;
  localparam int FMT_DATA_BIT = 30;
  localparam logic [2:0] ST_TIMEOUT = 3'b111;
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} seq_state_t;
endpackage

// File: rtl/cfgreq_regs.sv
module cfgreq_regs
  import cfgreq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int TW = 16,
  parameter int unsigned TMO_DEF = 1000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_we,
  input  logic                          reg_re,
  input  logic [AW-1:0]                 reg_addr,
  input  logic [DW-1:0]                 reg_wdata,
  input  logic                          busy_i,
  input  logic [2:0]                    status_i,
  input  logic [DW-1:0]                 payload_i,
  output logic [NUM_HDR-1:0][DW-1:0]    hdr_o,
  output logic [DW-1:0]                 wdat_o,
  output logic [TW-1:0]                 tmo_o,
  output logic [DW-1:0]                 reg_rdata
);
  logic [DW-1:0] rd_mux;

  // combinational read select, registered below
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_HDR; i++)
      if (reg_addr == AW'(OFF_HDR0 + 12'(4 * i))) rd_mux = hdr_o[i];
    if (reg_addr == AW'(OFF_WDATA)) rd_mux = wdat_o;
    if (reg_addr == AW'(OFF_TMO))   rd_mux = DW'(tmo_o);
    if (reg_addr == AW'(OFF_RDATA)) rd_mux = payload_i;
    if (reg_addr == AW'(OFF_REQ)) begin
      rd_mux[7:5] = status_i;
      rd_mux[0]   = busy_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_o     <= '0;
      wdat_o    <= '0;
      tmo_o     <= TW'(TMO_DEF);
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        for (int i = 0; i < NUM_HDR; i++)
          if (reg_addr == AW'(OFF_HDR0 + 12'(4 * i))) hdr_o[i] <= reg_wdata;
        if (reg_addr == AW'(OFF_WDATA)) wdat_o <= reg_wdata;
        if (reg_addr == AW'(OFF_TMO))   tmo_o  <= reg_wdata[TW-1:0];
      end
      if (reg_re) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cfgreq_seq.sv
module cfgreq_seq
  import cfgreq_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [NUM_HDR-1:0][DW-1:0] hdr_i,
  input  logic [DW-1:0]              wdat_i,
  input  logic [TW-1:0]              tmo_i,
  input  logic                       tx_ready,
  input  logic                       cpl_valid,
  input  logic [2:0]                 cpl_status,
  input  logic [DW-1:0]              cpl_data,
  output logic                       busy_o,
  output logic [2:0]                 status_o,
  output logic [DW-1:0]              payload_o,
  output logic                       tx_valid,
  output logic [DW-1:0]              tx_data,
  output logic                       tx_last
);
  localparam int NBEAT = NUM_HDR + 1;
  localparam int BW    = $clog2(NBEAT);

  seq_state_t    st;
  logic [DW-1:0] snap [NBEAT];
  logic [BW-1:0] beat;
  logic [BW-1:0] last_idx;
  logic          has_data;
  logic [TW-1:0] timer;

  assign last_idx = has_data ? BW'(NBEAT - 1) : BW'(NUM_HDR - 1);
  assign busy_o   = (st != S_IDLE);
  assign tx_valid = (st == S_SEND);
  assign tx_data  = snap[beat];
  assign tx_last  = tx_valid && (beat == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      beat      <= '0;
      has_data  <= 1'b0;
      timer     <= '0;
      status_o  <= '0;
      payload_o <= '0;
      for (int i = 0; i < NBEAT; i++) snap[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_i) begin
            for (int i = 0; i < NUM_HDR; i++) snap[i] <= hdr_i[i];
            snap[NUM_HDR] <= wdat_i;
            has_data      <= hdr_i[0][FMT_DATA_BIT];
            beat          <= '0;
            status_o      <= '0;
            st            <= S_SEND;
          end
        end
        S_SEND: begin
          if (tx_ready) begin
            if (beat == last_idx) begin
              st    <= S_WAIT;
              timer <= '0;
            end else begin
              beat <= beat + BW'(1);
            end
          end
        end
        S_WAIT: begin
          if (cpl_valid) begin
            st       <= S_IDLE;
            status_o <= cpl_status;
            if (!has_data) payload_o <= cpl_data;
          end else if (timer == tmo_i) begin
            st       <= S_IDLE;
            status_o <= ST_TIMEOUT;
          end else begin
            timer <= timer + TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgreq_issuer.sv
module cfgreq_issuer
  import cfgreq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int TW = 16,
  parameter int unsigned TMO_DEF = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  input  logic          cpl_valid,
  input  logic [2:0]    cpl_status,
  input  logic [DW-1:0] cpl_data
);
  logic [NUM_HDR-1:0][DW-1:0] hdr_w;
  logic [DW-1:0]              wdat_w;
  logic [TW-1:0]              tmo_lim_w;
  logic                       busy_w;
  logic [2:0]                 status_w;
  logic [DW-1:0]              payload_w;
  logic                       start_w;

  assign start_w = reg_we && (reg_addr == AW'(OFF_REQ)) && reg_wdata[0];

  cfgreq_regs #(.DW(DW), .AW(AW), .TW(TW), .TMO_DEF(TMO_DEF)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy_i(busy_w), .status_i(status_w), .payload_i(payload_w),
    .hdr_o(hdr_w), .wdat_o(wdat_w), .tmo_o(tmo_lim_w), .reg_rdata(reg_rdata)
  );

  cfgreq_seq #(.DW(DW), .TW(TW)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_w),
    .hdr_i(hdr_w), .wdat_i(wdat_w), .tmo_i(tmo_lim_w),
    .tx_ready(tx_ready), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
    .cpl_data(cpl_data), .busy_o(busy_w), .status_o(status_w),
    .payload_o(payload_w), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last)
  );
endmodule

// File: rtl/cfgreq_issuer_chk.sv
module cfgreq_issuer_chk
  import cfgreq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wdata0,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          tx_last,
  input logic          cpl_valid,
  input logic [2:0]    cpl_status,
  input logic          busy,
  input logic [2:0]    status,
  input logic [TW-1:0] tmo_limit
);
  logic        trig;
  logic [TW:0] wcnt;

  assign trig = reg_we && (reg_addr == AW'(OFF_REQ)) && reg_wdata0;

  // cycles spent waiting for a completion
  always_ff @(posedge clk) begin
    if (rst || !busy || tx_valid) wcnt <= '0;
    else                          wcnt <= wcnt + 1'b1;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  assert_stream_busy_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  assert_start_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> status == 3'b000);

  assert_cpl_end_R6: assert property (@(posedge clk) disable iff (rst)
    busy && !tx_valid && cpl_valid |=> !busy && status == $past(cpl_status));

  assert_idle_cpl_R8: assert property (@(posedge clk) disable iff (rst)
    !busy && cpl_valid && !trig |=> !busy && status == $past(status));

  assert_send_cpl_R8: assert property (@(posedge clk) disable iff (rst)
    tx_valid && cpl_valid |=> busy);

  assert_window_R9: assert property (@(posedge clk) disable iff (rst)
    busy && !tx_valid |-> wcnt <= {1'b0, tmo_limit});

  assert_expire_R9: assert property (@(posedge clk) disable iff (rst)
    busy && !tx_valid && !cpl_valid && wcnt == {1'b0, tmo_limit}
    |=> !busy && status == 3'b111);
endmodule

bind cfgreq_issuer cfgreq_issuer_chk #(.DW(DW), .AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata0(reg_wdata[0]), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .cpl_valid(cpl_valid),
  .cpl_status(cpl_status), .busy(busy_w), .status(status_w),
  .tmo_limit(tmo_lim_w)
);

// File: tb/test_cfgreq_issuer.sv
`timescale 1ns/1ps
module test_cfgreq_issuer;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0, reg_re = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_last;
  logic        tx_ready = 0;
  logic [31:0] tx_data;
  logic        cpl_valid = 0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfgreq_issuer #(.DW(32), .AW(12), .TW(16), .TMO_DEF(40)) i_cfgreq_issuer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
    .cpl_data(cpl_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_st, m_timer, m_lim;
  logic [31:0] m_q[$];
  logic [31:0] m_h[3];
  logic [31:0] m_wd, m_pay, m_rdx;
  logic [2:0]  m_status;
  bit          m_wr, m_rdp;

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h460: return m_h[0];
      12'h464: return m_h[1];
      12'h468: return m_h[2];
      12'h470: return m_wd;
      12'h488: return {24'b0, m_status, 4'b0, m_st != 0};
      12'h48C: return m_pay;
      12'h490: return 32'(m_lim);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_timer = 0; m_lim = 40; m_q = {};
      m_h[0] = 0; m_h[1] = 0; m_h[2] = 0; m_wd = 0; m_pay = 0;
      m_status = 0; m_wr = 0; m_rdp = 0; m_rdx = 0;
    end else begin
      m_rdp = reg_re;
      if (reg_re) m_rdx = model_read(reg_addr);
      case (m_st)
        0: if (reg_we && reg_addr == 12'h488 && reg_wdata[0]) begin
             m_q = {m_h[0], m_h[1], m_h[2]};
             m_wr = m_h[0][30];
             if (m_wr) m_q.push_back(m_wd);
             m_status = 0;
             m_st = 1;
           end
        1: if (tx_ready) begin
             void'(m_q.pop_front());
             if (m_q.size() == 0) begin m_st = 2; m_timer = 0; end
           end
        default: begin
          if (cpl_valid) begin
            m_st = 0; m_status = cpl_status;
            if (!m_wr) m_pay = cpl_data;
          end else if (m_timer == m_lim) begin
            m_st = 0; m_status = 3'b111;
          end else m_timer++;
        end
      endcase
      if (reg_we) case (reg_addr)
        12'h460: m_h[0] = reg_wdata;
        12'h464: m_h[1] = reg_wdata;
        12'h468: m_h[2] = reg_wdata;
        12'h470: m_wd = reg_wdata;
        12'h490: m_lim = int'(reg_wdata[15:0]);
        default: ;
      endcase
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 tx_valid", 32'(tx_valid), 32'(m_st == 1));
      if (m_st == 1) begin
        check("R4 tx_data", tx_data, m_q[0]);
        check("R4 tx_last", 32'(tx_last), 32'(m_q.size() == 1));
      end
      if (m_rdp) check("R2 reg_rdata", reg_rdata, m_rdx);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_expect(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic cpl_now(logic [2:0] s, logic [31:0] d);
    cpl_valid = 1; cpl_status = s; cpl_data = d;
    @(negedge clk); cpl_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_expect(12'h488, 32'h0, "R1 request reg");
    rd_expect(12'h48C, 32'h0, "R1 read data");
    rd_expect(12'h490, 32'd40, "R1 timeout limit");
    check("R1 tx_valid", 32'(tx_valid), 32'h0);
    // R2 register map
    wr(12'h460, 32'h0400_0001);
    wr(12'h464, 32'h0000_000C);
    wr(12'h468, 32'h0219_0010);
    wr(12'h470, 32'hDEAD_BEEF);
    wr(12'h490, 32'd4);
    rd_expect(12'h460, 32'h0400_0001, "R2 hdr0");
    rd_expect(12'h464, 32'h0000_000C, "R2 hdr1");
    rd_expect(12'h468, 32'h0219_0010, "R2 hdr2");
    rd_expect(12'h470, 32'hDEAD_BEEF, "R2 wdata");
    rd_expect(12'h490, 32'd4, "R2 timeout");
    tx_ready = 1;
    // R9 timeout with no completion
    wr(12'h488, 32'h1);
    repeat (20) @(negedge clk);
    rd_expect(12'h488, 32'hE0, "R9 timeout status");
    rd_expect(12'h48C, 32'h0, "R9 read data kept");
    // R3 start clears status, R6 read completion
    wr(12'h488, 32'h1);
    rd_expect(12'h488, 32'h1, "R3 busy and cleared status");
    repeat (3) @(negedge clk);
    cpl_now(3'b000, 32'h1234_5678);
    rd_expect(12'h488, 32'h0, "R6 read done");
    rd_expect(12'h48C, 32'h1234_5678, "R6 payload captured");
    // R4/R5/R7/R8 write request with backpressure
    wr(12'h490, 32'd30);
    wr(12'h460, 32'h4400_0001);
    wr(12'h464, 32'h0000_000F);
    tx_ready = 0;
    wr(12'h488, 32'h1);
    wr(12'h460, 32'h0400_0002);     // R5 rewrite during request
    wr(12'h470, 32'h0BAD_0BAD);     // R5 rewrite during request
    wr(12'h488, 32'h1);             // R7 second trigger ignored
    cpl_now(3'b101, 32'h0000_0999); // R8 completion while sending
    rd_expect(12'h488, 32'h1, "R7 R8 still busy");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); tx_ready = i[0];
    end
    tx_ready = 1;
    repeat (2) @(negedge clk);
    cpl_now(3'b010, 32'hAAAA_5555);
    rd_expect(12'h488, 32'h40, "R6 write status");
    rd_expect(12'h48C, 32'h1234_5678, "R6 write keeps read data");
    // R8 completion while idle
    cpl_now(3'b001, 32'h0000_0055);
    rd_expect(12'h488, 32'h40, "R8 idle status kept");
    rd_expect(12'h48C, 32'h1234_5678, "R8 idle data kept");
    // R9 completion exactly at the limit is accepted
    wr(12'h490, 32'd3);
    wr(12'h488, 32'h1);
    while (!(tx_valid && tx_last)) @(negedge clk);
    @(negedge clk);
    repeat (3) @(negedge clk);
    cpl_now(3'b001, 32'hCAFE_F00D);
    rd_expect(12'h488, 32'h20, "R9 completion at limit");
    rd_expect(12'h48C, 32'hCAFE_F00D, "R9 payload at limit");
    // R9 one cycle past the limit times out
    wr(12'h488, 32'h1);
    while (!(tx_valid && tx_last)) @(negedge clk);
    @(negedge clk);
    repeat (4) @(negedge clk);
    cpl_now(3'b001, 32'h1111_2222);
    rd_expect(12'h488, 32'hE0, "R9 late completion times out");
    rd_expect(12'h48C, 32'hCAFE_F00D, "R9 late payload dropped");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule